// File: doc/BRIEF.md
# Queued Break and Idle Serial Transmitter

This block is the transmit half of an asynchronous serial port. Software writes one byte at a time into a single-entry holding buffer. On a baud tick the byte moves into a shift register, which sends it on the serial line as a start bit, eight data bits and a stop bit. A baud-rate tick input paces every bit. Two status outputs follow the buffer and the line: one shows that the holding buffer can take another byte, and the other shows that everything has been sent.

Besides data characters, the transmitter sends two special characters that are queued behind the frame in progress. A break is a full character time held at 0. An idle character is a full character time held at 1. A pulse on the break control queues a break. Turning the enable on queues an idle character. Turning the enable off does not release the line at once: a pin-ownership output stays high until the current frame and any queued break or idle character have gone out.

Top module: `uartx_top`

## Requirements
- R1: A buffered byte moves into the shifter only on a clock edge where `baudTick` is 1. The data-empty flag is set on that same edge.
- R2: A data frame is ten bit periods long, and each bit period runs from one baud tick to the next. The first bit is a start bit of 0, then the eight data bits go out least significant bit first, and the last bit is a stop bit of 1. `txd` shows the start bit right after the loading tick.
- R3: A write strobe stores `wrData` in the buffer and clears both the data-empty flag and the transmit-complete flag on the next edge.
- R4: When a frame ends and nothing is waiting to be sent, the shifter goes idle. The transmit-complete flag is then set and `txd` stays at 1.
- R5: When `sendBreak` goes from 1 to 0, one break is queued. A break is ten bit periods of 0 on `txd`, and it starts on the first tick at which the shifter is free.
- R6: If `sendBreak` is still 1 on the tick that loads a break, another break is queued behind it.
- R7: When `txEnable` goes from 0 to 1, one idle character is queued. An idle character is ten bit periods of 1, and the shifter counts as busy while it goes out.
- R8: When the shifter becomes free, a queued break goes first, then a queued idle character, then a buffered byte.
- R9: After `txEnable` is cleared, `pinOwned` stays 1 until the frame in progress and any queued break or idle character have finished. It then drops to 0, and `txd` stays at 1.
- R10: If `txEnable` returns to 1 before the frame in progress ends, `pinOwned` never drops.
- R11: While `txEnable` is 0, a buffered byte is held and not sent, and the data-empty flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| baudTick | input | 1 | One-cycle pulse at each bit boundary |
| txEnable | input | 1 | Transmitter enable; a rising edge queues an idle character |
| sendBreak | input | 1 | Break control; a falling edge queues a break |
| wrStrobe | input | 1 | Writes `wrData` into the holding buffer |
| wrData | input | 8 | Byte to send |
| txd | output | 1 | Serial output, idle high |
| dataEmpty | output | 1 | Holding buffer can take a byte |
| txComplete | output | 1 | No frame in progress and nothing buffered |
| pinOwned | output | 1 | Transmitter is driving the line |

## Verification
Each baud tick is one clock wide and is applied on a falling edge, so the rising edge that follows consumes it. After that edge, `txd` shows the bit that the tick started, and the data-empty flag already reflects any load. The bench samples on the next falling edge. A write changes both flags one edge after the strobe. `pinOwned` follows `txEnable` and the busy state without delay, so it is checked on the same falling edge on which the enable changes. The bench reads each frame one bit per tick and compares it with the ten-bit pattern it builds from the byte, which is how all 256 data values and the break, idle and priority orderings are checked.

// File: rtl/uartx_pkg.sv
package uartx_pkg;
  typedef struct packed {
    logic loadData;
    logic loadBreak;
    logic loadIdle;
    logic shift;
  } txStrobe_t;
endpackage

// File: rtl/uartx_ctrl.sv
module uartx_ctrl
  import uartx_pkg::*;
#(
  parameter int FRAME_BITS = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      txEnable,
  input  logic      sendBreak,
  input  logic      wrStrobe,
  output txStrobe_t strobe,
  output logic      dataEmpty,
  output logic      txComplete,
  output logic      pinOwned
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic             busy;
  logic [CNT_W-1:0] bitCnt;
  logic             brkPend;
  logic             idlePend;
  logic             enPrev;
  logic             brkPrev;
  logic             lastBit;
  logic             shifterFree;
  logic             anyLoad;
  logic             goIdle;

  assign lastBit     = busy && (bitCnt == LAST_BIT);
  assign shifterFree = !busy || lastBit;

  // Free shifter takes the most urgent request: break, then idle, then data.
  always_comb begin
    strobe = '0;
    if (baudTick && shifterFree) begin
      if (brkPend)                     strobe.loadBreak = 1'b1;
      else if (idlePend)               strobe.loadIdle  = 1'b1;
      else if (!dataEmpty && txEnable) strobe.loadData  = 1'b1;
    end
    anyLoad      = strobe.loadBreak || strobe.loadIdle || strobe.loadData;
    strobe.shift = baudTick && busy && !anyLoad;
    goIdle       = baudTick && lastBit && !anyLoad;
  end

  assign pinOwned = txEnable || busy || brkPend || idlePend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      bitCnt     <= '0;
      brkPend    <= 1'b0;
      idlePend   <= 1'b0;
      enPrev     <= 1'b0;
      brkPrev    <= 1'b0;
      dataEmpty  <= 1'b1;
      txComplete <= 1'b1;
    end else begin
      enPrev  <= txEnable;
      brkPrev <= sendBreak;

      if (anyLoad) begin
        busy   <= 1'b1;
        bitCnt <= '0;
      end else if (strobe.shift) begin
        if (lastBit) busy <= 1'b0;
        else         bitCnt <= bitCnt + 1'b1;
      end

      brkPend  <= (brkPend && !strobe.loadBreak)
                || (brkPrev && !sendBreak)
                || (strobe.loadBreak && sendBreak);
      idlePend <= (idlePend && !strobe.loadIdle) || (txEnable && !enPrev);

      if (wrStrobe) begin
        dataEmpty  <= 1'b0;
        txComplete <= 1'b0;
      end else begin
        if (strobe.loadData)         dataEmpty  <= 1'b1;
        if (goIdle && dataEmpty)     txComplete <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uartx_shift.sv
module uartx_shift
  import uartx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrStrobe,
  input  logic [DATA_BITS-1:0] wrData,
  input  txStrobe_t            strobe,
  output logic                 txd
);
  localparam int FRAME_BITS = DATA_BITS + 2;

  logic [DATA_BITS-1:0]  holdBuf;
  logic [FRAME_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdBuf  <= '0;
      shiftReg <= '1;
    end else begin
      if (wrStrobe) holdBuf <= wrData;
      if (strobe.loadData)       shiftReg <= {1'b1, holdBuf, 1'b0};
      else if (strobe.loadBreak) shiftReg <= '0;
      else if (strobe.loadIdle)  shiftReg <= '1;
      else if (strobe.shift)     shiftReg <= {1'b1, shiftReg[FRAME_BITS-1:1]};
    end
  end

  assign txd = shiftReg[0];
endmodule

// File: rtl/uartx_top.sv
module uartx_top
  import uartx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 txEnable,
  input  logic                 sendBreak,
  input  logic                 wrStrobe,
  input  logic [DATA_BITS-1:0] wrData,
  output logic                 txd,
  output logic                 dataEmpty,
  output logic                 txComplete,
  output logic                 pinOwned
);
  localparam int FRAME_BITS = DATA_BITS + 2;

  txStrobe_t strobe;

  uartx_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txEnable(txEnable),
    .sendBreak(sendBreak), .wrStrobe(wrStrobe), .strobe(strobe),
    .dataEmpty(dataEmpty), .txComplete(txComplete), .pinOwned(pinOwned)
  );

  uartx_shift #(.DATA_BITS(DATA_BITS)) u_shift (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .strobe(strobe), .txd(txd)
  );
endmodule

// File: rtl/uartx_checker.sv
module uartx_checker (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic txEnable,
  input logic wrStrobe,
  input logic txd,
  input logic dataEmpty,
  input logic txComplete,
  input logic pinOwned
);
  a_r1_empty_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataEmpty) |-> $past(baudTick));

  a_r2_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txd) |-> $past(baudTick));

  a_r3_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> (!dataEmpty && !txComplete));

  a_r4_complete_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txComplete) |-> $past(baudTick));

  a_r4_complete_means_empty: assert property (@(posedge clk) disable iff (!rstN)
    txComplete |-> dataEmpty);

  a_r9_released_line_high: assert property (@(posedge clk) disable iff (!rstN)
    !pinOwned |-> txd);

  a_r10_no_drop_while_enabled: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinOwned) |-> !txEnable);
endmodule

bind uartx_top uartx_checker u_chk (
  .clk(clk), .rstN(rstN), .baudTick(baudTick), .txEnable(txEnable),
  .wrStrobe(wrStrobe), .txd(txd), .dataEmpty(dataEmpty),
  .txComplete(txComplete), .pinOwned(pinOwned)
);

// File: tb/uartx_top_bench.sv
module uartx_top_bench;
  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       txEnable = 1'b0;
  logic       sendBreak = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic       txd, dataEmpty, txComplete, pinOwned;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  uartx_top u_uartx_top (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txEnable(txEnable),
    .sendBreak(sendBreak), .wrStrobe(wrStrobe), .wrData(wrData),
    .txd(txd), .dataEmpty(dataEmpty), .txComplete(txComplete),
    .pinOwned(pinOwned)
  );

  task automatic check(input logic act, input logic exp, input string req);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One baud tick, consumed by the next rising edge; returns on a falling edge.
  task automatic step();
    @(negedge clk) baudTick = 1'b1;
    @(negedge clk) baudTick = 1'b0;
    repeat (TICK_DIV - 2) @(negedge clk);
  endtask

  task automatic writeByte(input logic [7:0] v);
    @(negedge clk) begin wrStrobe = 1'b1; wrData = v; end
    @(negedge clk) wrStrobe = 1'b0;
  endtask

  task automatic frameBits(input logic [9:0] bits, input int firstIdx, input string req);
    for (int i = firstIdx; i < 10; i++) begin
      step();
      check(txd, bits[i], req);
    end
  endtask

  function automatic logic [9:0] dataFrame(input logic [7:0] v);
    return {1'b1, v, 1'b0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txd, 1'b1, "R4 reset line");
    check(dataEmpty, 1'b1, "R1 reset empty");
    check(txComplete, 1'b1, "R4 reset complete");
    check(pinOwned, 1'b0, "R9 reset released");

    // R7: enabling queues one idle character
    txEnable = 1'b1;
    #1 check(pinOwned, 1'b1, "R7 owned on enable");
    frameBits(10'h3FF, 0, "R7 idle char");
    step();
    check(txd, 1'b1, "R7 after idle");

    // R1 R2 R3 R4: back-to-back sweep over every byte value
    writeByte(8'h00);
    check(dataEmpty, 1'b0, "R3 write clears empty");
    check(txComplete, 1'b0, "R3 write clears complete");
    for (int v = 0; v < 256; v++) begin
      for (int i = 0; i < 10; i++) begin
        step();
        check(txd, dataFrame(8'(v))[i], "R2 data bit");
        if (i == 0) begin
          check(dataEmpty, 1'b1, "R1 empty on load");
          if (v < 255) writeByte(8'(v + 1));
        end
      end
    end
    step();
    check(txd, 1'b1, "R4 line idle");
    check(txComplete, 1'b1, "R4 complete set");

    // R5: single break pulse
    @(negedge clk) sendBreak = 1'b1;
    @(negedge clk) sendBreak = 1'b0;
    frameBits(10'h000, 0, "R5 break");
    step();
    check(txd, 1'b1, "R5 after break");

    // R6: break control still high at load queues a second break
    @(negedge clk) sendBreak = 1'b1;
    @(negedge clk) sendBreak = 1'b0;
    @(negedge clk) sendBreak = 1'b1;
    step();
    check(txd, 1'b0, "R6 first break start");
    sendBreak = 1'b0;
    frameBits(10'h000, 1, "R6 first break");
    frameBits(10'h000, 0, "R6 second break");
    step();
    check(txd, 1'b1, "R6 only two breaks");

    // R8 R10: queue data, break and idle behind a frame in progress
    writeByte(8'hA5);
    step();
    check(txd, 1'b0, "R8 frame A start");
    writeByte(8'h3C);
    @(negedge clk) sendBreak = 1'b1;
    @(negedge clk) begin sendBreak = 1'b0; txEnable = 1'b0; end
    #1 check(pinOwned, 1'b1, "R10 owned while toggled");
    @(negedge clk) txEnable = 1'b1;
    #1 check(pinOwned, 1'b1, "R10 owned after re-enable");
    frameBits(dataFrame(8'hA5), 1, "R8 frame A");
    frameBits(10'h000, 0, "R8 break first");
    frameBits(10'h3FF, 0, "R8 idle second");
    frameBits(dataFrame(8'h3C), 0, "R8 data last");
    step();
    check(txComplete, 1'b1, "R4 complete after queue");

    // R9: disable mid-frame keeps ownership until the frame ends
    writeByte(8'h5A);
    step();
    txEnable = 1'b0;
    #1 check(pinOwned, 1'b1, "R9 owned after disable");
    for (int i = 1; i < 10; i++) begin
      step();
      check(txd, dataFrame(8'h5A)[i], "R9 frame continues");
      check(pinOwned, 1'b1, "R9 still owned");
    end
    step();
    check(pinOwned, 1'b0, "R9 released");
    check(txd, 1'b1, "R9 line high");
    check(txComplete, 1'b1, "R9 complete");

    // R11: byte held while disabled, then idle precedes it
    writeByte(8'hC3);
    for (int i = 0; i < 3; i++) begin
      step();
      check(txd, 1'b1, "R11 held line");
      check(dataEmpty, 1'b0, "R11 held empty");
      check(pinOwned, 1'b0, "R11 not owned");
    end
    @(negedge clk) txEnable = 1'b1;
    frameBits(10'h3FF, 0, "R11 idle before data");
    frameBits(dataFrame(8'hC3), 0, "R11 held data");
    step();
    check(txComplete, 1'b1, "R11 done");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule